// File: doc/BRIEF.md
# Receive Parallel Output Formatter

This block sits between a deserializer and a protocol device. The deserializer delivers one aligned 10-bit code group per byte period, marked by a one-cycle strobe. The formatter holds each group and drives it out in one of two bus formats. The first is a full 10-bit parallel word held for the whole byte period. The second is a 5-bit double-data-rate stream: the low half of the group comes first and the high half follows.

The block also produces two receive byte clocks. Everything runs from one fast reference clock. A byte period spans `BYTE_CYC` reference cycles, and the byte clocks are registered levels derived from a phase counter, so no real clock is derived.

Two mode inputs set the clocking. `ddr_sel` chooses the bus format. `clk_mode` chooses between a pair of complementary half-rate clocks and a single full-rate clock. When `ddr_sel` is high it forces the full-rate clock and `clk_mode` has no effect. Both inputs are sampled only when a group is accepted, so a mode change always starts cleanly on a group boundary.

Top module: `rx_out_fmt`

## Requirements
- R1: While `rst_n` is low, and after its release until the first strobe, `rx_data` is all zero and both `bclk_a` and `bclk_b` are low. The latched format resets to the 10-bit bus.
- R2: In the 10-bit format (`ddr_sel` low when the group was accepted), `rx_data` equals the accepted group for the `BYTE_CYC` cycles that start one cycle after the strobe edge.
- R3: In the 5-bit format (`ddr_sel` high when accepted), `rx_data[4:0]` carries group bits [4:0] for the first `BYTE_CYC/2` cycles of the byte period and bits [9:5] for the remaining cycles. `rx_data[9:5]` is zero throughout.
- R4: When `ddr_sel` is low and `clk_mode` is high at acceptance, `bclk_a` is high for the first `BYTE_CYC/2` cycles of the byte period and low for the rest, and `bclk_b` stays low.
- R5: When `ddr_sel` is high at acceptance, the clock outputs behave as in R4 whatever the value of `clk_mode`.
- R6: When both mode inputs are low at acceptance, `bclk_b` is the complement of `bclk_a` and both stay constant over the byte period. `bclk_a` is high during the 1st, 3rd, 5th and later odd accepted groups counted from reset, and low during the even ones. The count includes groups accepted in other modes.
- R7: Changes on `ddr_sel` or `clk_mode` between strobes do not affect the group in progress. They take effect from the next accepted group.
- R8: If no strobe arrives after the last phase of a byte period, the outputs hold the values of that last phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_strobe | input | 1 | One-cycle pulse marking a new code group |
| grp_data | input | GRP_W | Aligned code group from the deserializer |
| ddr_sel | input | 1 | Bus format: 0 selects 10-bit, 1 selects 5-bit double-data-rate |
| clk_mode | input | 1 | Clocking with 10-bit bus: 0 selects paired half-rate, 1 selects single full-rate |
| rx_data | output | GRP_W | Parallel data to the protocol device |
| bclk_a | output | 1 | First receive byte clock |
| bclk_b | output | 1 | Second receive byte clock |

## Verification
Four properties are checked on every cycle:
- The latched format stays frozen between strobes.
- `bclk_b` is quiet whenever full-rate clocking is latched.
- The two clocks are complementary in half-rate clocking.
- The upper data bits are zero in the 5-bit format.

Only the bench scenarios can show the following:
- The phase-by-phase data ordering and the clock duty over a byte period.
- The alternation of the half-rate clocks across successive groups.
- That `clk_mode` has no effect in the 5-bit format.
- That a mid-period mode change is deferred.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

    // Format latched at each accepted code group.
    typedef struct packed {
        logic ddr;   // 1: 5-bit double-data-rate bus
        logic half;  // 1: paired half-rate byte clocks
    } fmt_t;

    localparam fmt_t FMT_RESET = '{ddr: 1'b0, half: 1'b1};

endpackage

// File: rtl/rxfmt_seq.sv
module rxfmt_seq
    import rxfmt_pkg::*;
#(
    parameter int GRP_W    = 10,
    parameter int BYTE_CYC = 4,
    localparam int PW      = (BYTE_CYC > 2) ? $clog2(BYTE_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_strobe,
    input  logic [GRP_W-1:0] grp_data,
    input  logic             ddr_sel,
    input  logic             clk_mode,
    output logic [PW-1:0]    phase,
    output logic [GRP_W-1:0] grp,
    output fmt_t             fmt,
    output logic             par,
    output logic             live
);

    localparam logic [PW-1:0] LAST = PW'(BYTE_CYC - 1);

    typedef struct packed {
        logic [PW-1:0]    phase;
        logic [GRP_W-1:0] grp;
        fmt_t             fmt;
        logic             par;
        logic             live;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (grp_strobe) begin
            st_d.phase    = '0;
            st_d.grp      = grp_data;
            st_d.fmt.ddr  = ddr_sel;
            st_d.fmt.half = ~ddr_sel & ~clk_mode;
            st_d.par      = ~st_q.par;
            st_d.live     = 1'b1;
        end else if (st_q.phase != LAST) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= LAST;
            st_q.grp   <= '0;
            st_q.fmt   <= FMT_RESET;
            st_q.par   <= 1'b0;
            st_q.live  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign grp   = st_q.grp;
    assign fmt   = st_q.fmt;
    assign par   = st_q.par;
    assign live  = st_q.live;

    // Format only moves at a group boundary.
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_strobe |=> $stable(fmt));

endmodule

// File: rtl/rxfmt_clkgen.sv
module rxfmt_clkgen
    import rxfmt_pkg::*;
#(
    parameter int BYTE_CYC = 4,
    localparam int PW      = (BYTE_CYC > 2) ? $clog2(BYTE_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    input  fmt_t          fmt,
    input  logic          par,
    input  logic          live,
    output logic          bclk_a,
    output logic          bclk_b
);

    localparam logic [PW-1:0] HALF_P = PW'(BYTE_CYC / 2);

    typedef struct packed {
        logic a;
        logic b;
    } ck_t;

    ck_t ck_d, ck_q;

    always_comb begin
        ck_d = '0;
        if (live) begin
            if (fmt.half) begin
                ck_d.a = par;
                ck_d.b = ~par;
            end else begin
                ck_d.a = (phase < HALF_P);
                ck_d.b = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q <= '0;
        end else begin
            ck_q <= ck_d;
        end
    end

    assign bclk_a = ck_q.a;
    assign bclk_b = ck_q.b;

    // Second clock is quiet under full-rate clocking (R4, R5).
    assert_b_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt.half |=> !bclk_b);

    // Half-rate clocks are opposite in phase once running.
    assert_half_comp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt.half && live) |=> (bclk_a != bclk_b));

endmodule

// File: rtl/rxfmt_datamux.sv
module rxfmt_datamux
    import rxfmt_pkg::*;
#(
    parameter int GRP_W    = 10,
    parameter int BYTE_CYC = 4,
    localparam int PW      = (BYTE_CYC > 2) ? $clog2(BYTE_CYC) : 1,
    localparam int NIB_W   = GRP_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    phase,
    input  logic [GRP_W-1:0] grp,
    input  fmt_t             fmt,
    output logic [GRP_W-1:0] rx_data
);

    localparam logic [PW-1:0] HALF_P = PW'(BYTE_CYC / 2);

    logic [GRP_W-1:0] dat_d, dat_q;

    always_comb begin
        dat_d = grp;
        if (fmt.ddr) begin
            dat_d = '0;
            if (phase < HALF_P) begin
                dat_d[NIB_W-1:0] = grp[NIB_W-1:0];
            end else begin
                dat_d[NIB_W-1:0] = grp[GRP_W-1:NIB_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else begin
            dat_q <= dat_d;
        end
    end

    assign rx_data = dat_q;

    // Upper lanes idle on the reduced bus.
    assert_ddr_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fmt.ddr |=> (rx_data[GRP_W-1:NIB_W] == '0));

endmodule

// File: rtl/rx_out_fmt.sv
module rx_out_fmt
    import rxfmt_pkg::*;
#(
    parameter int GRP_W    = 10,
    parameter int BYTE_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_strobe,
    input  logic [GRP_W-1:0] grp_data,
    input  logic             ddr_sel,
    input  logic             clk_mode,
    output logic [GRP_W-1:0] rx_data,
    output logic             bclk_a,
    output logic             bclk_b
);

    localparam int PW = (BYTE_CYC > 2) ? $clog2(BYTE_CYC) : 1;

    logic [PW-1:0]    phase;
    logic [GRP_W-1:0] grp;
    fmt_t             fmt;
    logic             par;
    logic             live;

    rxfmt_seq #(.GRP_W(GRP_W), .BYTE_CYC(BYTE_CYC)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_strobe (grp_strobe),
        .grp_data   (grp_data),
        .ddr_sel    (ddr_sel),
        .clk_mode   (clk_mode),
        .phase      (phase),
        .grp        (grp),
        .fmt        (fmt),
        .par        (par),
        .live       (live)
    );

    rxfmt_clkgen #(.BYTE_CYC(BYTE_CYC)) clkgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase  (phase),
        .fmt    (fmt),
        .par    (par),
        .live   (live),
        .bclk_a (bclk_a),
        .bclk_b (bclk_b)
    );

    rxfmt_datamux #(.GRP_W(GRP_W), .BYTE_CYC(BYTE_CYC)) datamux_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .grp     (grp),
        .fmt     (fmt),
        .rx_data (rx_data)
    );

endmodule

// File: tb/rx_out_fmt_tb_top.sv
`timescale 1ns/1ps
module rx_out_fmt_tb_top;

    localparam int GRP_W    = 10;
    localparam int BYTE_CYC = 4;
    localparam int HALF     = BYTE_CYC / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grp_strobe = 1'b0;
    logic [GRP_W-1:0] grp_data = '0;
    logic             ddr_sel = 1'b0;
    logic             clk_mode = 1'b0;
    logic [GRP_W-1:0] rx_data;
    logic             bclk_a;
    logic             bclk_b;

    int n_chk = 0;
    int n_bad = 0;
    int n_strobes = 0;

    logic [GRP_W-1:0] last_g;
    logic             last_md, last_mc, last_par;

    always #4 clk = ~clk;

    rx_out_fmt #(.GRP_W(GRP_W), .BYTE_CYC(BYTE_CYC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_strobe (grp_strobe),
        .grp_data   (grp_data),
        .ddr_sel    (ddr_sel),
        .clk_mode   (clk_mode),
        .rx_data    (rx_data),
        .bclk_a     (bclk_a),
        .bclk_b     (bclk_b)
    );

    task automatic chk(input string tag, input logic [GRP_W-1:0] got, input logic [GRP_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [GRP_W-1:0] exp_data(input logic [GRP_W-1:0] g, input logic md, input int k);
        logic [GRP_W-1:0] r;
        if (!md) return g;
        r = '0;
        r[4:0] = (k < HALF) ? g[4:0] : g[9:5];
        return r;
    endfunction

    task automatic chk_phase(input string xtag, input logic [GRP_W-1:0] g, input logic md,
                             input logic mc, input logic pr, input int k);
        string dtag, ctag;
        logic ea, eb;
        dtag = md ? "R3" : "R2";
        ctag = md ? "R5" : (mc ? "R4" : "R6");
        if (md || mc) begin
            ea = (k < HALF);
            eb = 1'b0;
        end else begin
            ea = pr;
            eb = ~pr;
        end
        chk({dtag, xtag, " data"}, rx_data, exp_data(g, md, k));
        chk({ctag, xtag, " bclk_a"}, {9'b0, bclk_a}, {9'b0, ea});
        chk({ctag, xtag, " bclk_b"}, {9'b0, bclk_b}, {9'b0, eb});
    endtask

    // Streams n groups back to back; optionally flips ddr_sel at iteration flip_c.
    task automatic run_seq(input int n, input logic ddr0, input logic cm0,
                           input int flip_c, input string xtag, input int seed);
        logic [GRP_W-1:0] gv [8];
        logic md [8];
        logic mc [8];
        logic pr [8];
        ddr_sel  = ddr0;
        clk_mode = cm0;
        for (int c = 0; c <= 4 * n + 1; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                int j = c - 2;
                int i = j / 4;
                if (i < n) chk_phase(xtag, gv[i], md[i], mc[i], pr[i], j % 4);
            end
            if (c == flip_c) ddr_sel = ~ddr_sel;
            if ((c % 4 == 0) && (c / 4 < n)) begin
                int i = c / 4;
                gv[i] = 10'h2A5 ^ GRP_W'(c * 53 + seed * 97 + 1);
                md[i] = ddr_sel;
                mc[i] = clk_mode;
                n_strobes++;
                pr[i] = n_strobes[0];
                grp_strobe = 1'b1;
                grp_data   = gv[i];
                last_g = gv[i]; last_md = md[i]; last_mc = mc[i]; last_par = pr[i];
            end else begin
                grp_strobe = 1'b0;
            end
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset data", rx_data, '0);
        chk("R1 reset clocks", {8'b0, bclk_a, bclk_b}, '0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 idle data", rx_data, '0);
        chk("R1 idle clocks", {8'b0, bclk_a, bclk_b}, '0);
    endtask

    task automatic test_hold();
        repeat (4) @(negedge clk);
        chk_phase(" R8 hold", last_g, last_md, last_mc, last_par, BYTE_CYC - 1);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        run_seq(4, 1'b0, 1'b0, -1, "", 1);
        test_hold();
        run_seq(3, 1'b0, 1'b1, -1, "", 2);
        test_hold();
        run_seq(3, 1'b1, 1'b0, -1, "", 3);
        run_seq(3, 1'b1, 1'b1, -1, "", 4);
        test_hold();
        run_seq(2, 1'b0, 1'b1, 2, " R7 flip", 5);
        run_seq(2, 1'b1, 1'b0, 2, " R7 flip", 6);
        run_seq(3, 1'b0, 1'b0, -1, "", 7);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule